// File: doc/BRIEF.md
# Split L1 Access Dispatcher

This block sits between the processor request queue and the coherence controller of a split instruction/data first-level cache. It takes one request at a time, made of a kind and a line address. It compares the line against presence and free-way indications from the instruction and data tag stubs. In response it emits exactly one event per cycle, which is one of load, ifetch, store or replace, together with the line the event concerns and a flag that names the cache holding that line.

Instruction fetches belong to the instruction cache. Loads, stores and atomics belong to the data cache. If a line sits in the cache it does not belong to, the block evicts it from there before anything else happens, so a line is never tagged in both caches. If the proper cache has no room, the block asks for the victim that this cache nominates to be replaced. The request stays at the head of the queue until its own event, not a replacement, has been accepted. A request with an unknown kind is dropped and reported.

Top module: `l1_split_dispatch`

## Requirements
- R1: A request of kind 1 (ifetch) is resolved against the instruction cache. On a hit there, event code 1 (ifetch) is issued for the requested line with `evt_icache` = 1.
- R2: Requests of kind 0 (load), 2 (store) and 3 (atomic) are resolved against the data cache. A load hit there issues event code 0 for the requested line with `evt_icache` = 0.
- R3: An atomic request (kind 3) issues the same event code 2 as a plain store.
- R4: A request kind of 4 to 7 raises `req_error` for the cycle it is presented, emits no event, and is dropped: `req_ready` is 1 in that cycle.
- R5: If the line misses in its proper cache but is present in the other cache, event code 3 (replace) is issued for the requested line, with `evt_icache` naming the other cache.
- R6: If the line is absent from both caches and the proper cache reports a free way, the request's own event is issued for the requested line in the proper cache.
- R7: If the line is absent from both caches and the proper cache has no free way, event code 3 is issued for the victim line that the proper cache supplies, with `evt_icache` naming the proper cache.
- R8: `req_ready` rises only when the request's own event is valid and `evt_ready` is 1. A replace event, or an own event with `evt_ready` low, leaves `req_ready` at 0.
- R9: Presence in the wrong cache takes priority over the free-way and victim decision. A line is never tagged in both caches at once.
- R10: With no valid request, `evt_valid`, `req_ready` and `req_error` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present at the queue head |
| req_kind | input | 3 | 0 load, 1 ifetch, 2 store, 3 atomic, other codes illegal |
| req_line | input | LINE_W | Requested line address |
| req_ready | output | 1 | Pops the request from the queue |
| icache_hit | input | 1 | Line tagged in the instruction cache |
| icache_free | input | 1 | Instruction cache set has a free way |
| icache_victim | input | LINE_W | Instruction cache victim line |
| dcache_hit | input | 1 | Line tagged in the data cache |
| dcache_free | input | 1 | Data cache set has a free way |
| dcache_victim | input | LINE_W | Data cache victim line |
| evt_valid | output | 1 | Event present |
| evt_ready | input | 1 | Controller accepts the event |
| evt_kind | output | 2 | 0 load, 1 ifetch, 2 store, 3 replace |
| evt_line | output | LINE_W | Line the event applies to |
| evt_icache | output | 1 | 1 when the event targets the instruction cache |
| req_error | output | 1 | Illegal request kind seen |

## Verification
The routing is tried with hits in the proper cache, with the line found only in the wrong cache, with a miss that finds a free way, and with a miss into a full set. Each of these patterns gives a different mix of event code, line and cache flag. Separate patterns cover a line in the wrong cache while the proper set is full, which shows whether eviction is checked before the victim decision, and an atomic request, which must map to the store event. Back-pressure on the event output and illegal kinds show whether a request is held, popped or dropped.

// File: rtl/l1sd_pkg.sv
package l1sd_pkg;
   localparam int KIND_W = 3;

   localparam logic [KIND_W-1:0] RQ_LOAD   = 3'd0;
   localparam logic [KIND_W-1:0] RQ_IFETCH = 3'd1;
   localparam logic [KIND_W-1:0] RQ_STORE  = 3'd2;
   localparam logic [KIND_W-1:0] RQ_ATOMIC = 3'd3;

   typedef enum logic [1:0] {
      EV_LOAD   = 2'd0,
      EV_IFETCH = 2'd1,
      EV_STORE  = 2'd2,
      EV_REPL   = 2'd3
   } l1sd_event_e;

   typedef enum logic [1:0] {
      PATH_OWN_HIT,
      PATH_EVICT_OTHER,
      PATH_OWN_FILL,
      PATH_EVICT_VICTIM
   } l1sd_path_e;
endpackage

// File: rtl/l1sd_kind_decode.sv
module l1sd_kind_decode
   import l1sd_pkg::*;
(
   input  logic [KIND_W-1:0] kind,
   output l1sd_event_e       own_evt,
   output logic              want_icache,
   output logic              illegal
);
   always_comb begin
      own_evt     = EV_LOAD;
      want_icache = 1'b0;
      illegal     = 1'b0;
      unique case (kind)
         RQ_LOAD:   own_evt = EV_LOAD;
         RQ_IFETCH: begin
            own_evt     = EV_IFETCH;
            want_icache = 1'b1;
         end
         RQ_STORE,
         RQ_ATOMIC: own_evt = EV_STORE;
         default:   illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/l1sd_route.sv
module l1sd_route
   import l1sd_pkg::*;
#(
   parameter int LINE_W = 32
) (
   input  logic              want_icache,
   input  logic [LINE_W-1:0] req_line,
   input  logic              i_hit,
   input  logic              i_free,
   input  logic [LINE_W-1:0] i_victim,
   input  logic              d_hit,
   input  logic              d_free,
   input  logic [LINE_W-1:0] d_victim,
   output l1sd_path_e        path,
   output logic [LINE_W-1:0] tgt_line,
   output logic              tgt_icache
);
   logic              own_hit, oth_hit, own_free;
   logic [LINE_W-1:0] own_victim;

   always_comb begin
      own_hit    = want_icache ? i_hit    : d_hit;
      oth_hit    = want_icache ? d_hit    : i_hit;
      own_free   = want_icache ? i_free   : d_free;
      own_victim = want_icache ? i_victim : d_victim;
   end

   // priority: proper hit, wrong-cache eviction, free way, victim eviction
   always_comb begin
      if (own_hit)       path = PATH_OWN_HIT;
      else if (oth_hit)  path = PATH_EVICT_OTHER;
      else if (own_free) path = PATH_OWN_FILL;
      else               path = PATH_EVICT_VICTIM;
   end

   always_comb begin
      tgt_line   = req_line;
      tgt_icache = want_icache;
      unique case (path)
         PATH_EVICT_OTHER:  tgt_icache = ~want_icache;
         PATH_EVICT_VICTIM: tgt_line   = own_victim;
         default: ;
      endcase
   end
endmodule

// File: rtl/l1_split_dispatch.sv
module l1_split_dispatch
   import l1sd_pkg::*;
#(
   parameter int LINE_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [LINE_W-1:0] req_line,
   output logic              req_ready,
   input  logic              icache_hit,
   input  logic              icache_free,
   input  logic [LINE_W-1:0] icache_victim,
   input  logic              dcache_hit,
   input  logic              dcache_free,
   input  logic [LINE_W-1:0] dcache_victim,
   output logic              evt_valid,
   input  logic              evt_ready,
   output logic [1:0]        evt_kind,
   output logic [LINE_W-1:0] evt_line,
   output logic              evt_icache,
   output logic              req_error
);
   generate
      if (LINE_W < 4) begin : g_bad_width
         $error("l1_split_dispatch: LINE_W must be at least 4");
      end
      if (KIND_W != 3) begin : g_bad_kind
         $error("l1_split_dispatch: request kind field must be 3 bits");
      end
   endgenerate

   l1sd_event_e       own_evt;
   logic              want_icache, illegal;
   l1sd_path_e        path;
   logic [LINE_W-1:0] tgt_line;
   logic              tgt_icache;
   logic              is_own;

   l1sd_kind_decode u_dec (
      .kind        (req_kind),
      .own_evt     (own_evt),
      .want_icache (want_icache),
      .illegal     (illegal)
   );

   l1sd_route #(.LINE_W(LINE_W)) u_route (
      .want_icache (want_icache),
      .req_line    (req_line),
      .i_hit       (icache_hit),
      .i_free      (icache_free),
      .i_victim    (icache_victim),
      .d_hit       (dcache_hit),
      .d_free      (dcache_free),
      .d_victim    (dcache_victim),
      .path        (path),
      .tgt_line    (tgt_line),
      .tgt_icache  (tgt_icache)
   );

   always_comb begin
      is_own     = (path == PATH_OWN_HIT) || (path == PATH_OWN_FILL);
      evt_valid  = req_valid && !illegal;
      evt_kind   = is_own ? own_evt : EV_REPL;
      evt_line   = tgt_line;
      evt_icache = tgt_icache;
      req_error  = req_valid && illegal;
      req_ready  = req_error || (evt_valid && is_own && evt_ready);
   end

   AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      req_error |-> (req_ready && !evt_valid)); // R4
   AST_REPL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_kind == EV_REPL) |-> !req_ready); // R8
   AST_POP_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_error) |-> (evt_valid && evt_ready)); // R8
   AST_IFETCH_ICACHE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_kind == EV_IFETCH) |-> evt_icache); // R1
   AST_FOREIGN_LINE_REPL: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_line != req_line) |-> (evt_kind == EV_REPL)); // R7
   AST_NO_DUAL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !(icache_hit && dcache_hit)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!evt_valid && !req_ready && !req_error)); // R10
endmodule

// File: tb/tb_l1_split_dispatch.sv
module tb_l1_split_dispatch;
   localparam int LW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_kind = '0;
   logic [LW-1:0] req_line = '0;
   logic          req_ready;
   logic          icache_hit = 1'b0, icache_free = 1'b0;
   logic [LW-1:0] icache_victim = '0;
   logic          dcache_hit = 1'b0, dcache_free = 1'b0;
   logic [LW-1:0] dcache_victim = '0;
   logic          evt_valid;
   logic          evt_ready = 1'b1;
   logic [1:0]    evt_kind;
   logic [LW-1:0] evt_line;
   logic          evt_icache;
   logic          req_error;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   l1_split_dispatch #(.LINE_W(LW)) dut (.*);

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [2:0] k, input logic [LW-1:0] ln,
                        input logic ih, input logic ifr, input logic [LW-1:0] iv,
                        input logic dh, input logic dfr, input logic [LW-1:0] dv,
                        input logic er);
      @(negedge clk);
      req_valid = v; req_kind = k; req_line = ln;
      icache_hit = ih; icache_free = ifr; icache_victim = iv;
      dcache_hit = dh; dcache_free = dfr; dcache_victim = dv;
      evt_ready = er;
      #1;
   endtask

   task automatic expect_evt(input string tag, input logic [1:0] k, input logic [LW-1:0] ln,
                             input logic ic, input logic rdy);
      check({tag, " valid"}, evt_valid, 1'b1);
      check({tag, " kind"}, evt_kind, k);
      check({tag, " line"}, evt_line, ln);
      check({tag, " icache"}, evt_icache, ic);
      check({tag, " ready"}, req_ready, rdy);
      check({tag, " error"}, req_error, 1'b0);
   endtask

   task automatic t_idle();
      drive(0, 3'd0, 32'h10, 0, 1, 0, 0, 1, 0, 1);
      check("R10 valid", evt_valid, 0);
      check("R10 ready", req_ready, 0);
      check("R10 error", req_error, 0);
   endtask

   task automatic t_ifetch_hit();
      drive(1, 3'd1, 32'h1000, 1, 0, 32'hDEAD, 0, 0, 0, 1);
      expect_evt("R1 ifetch hit", 2'd1, 32'h1000, 1, 1);
   endtask

   task automatic t_load_hit();
      drive(1, 3'd0, 32'h2000, 0, 0, 0, 1, 0, 32'hBEEF, 1);
      expect_evt("R2 load hit", 2'd0, 32'h2000, 0, 1);
      drive(1, 3'd2, 32'h2040, 0, 0, 0, 1, 0, 32'hBEEF, 1);
      expect_evt("R2 store hit", 2'd2, 32'h2040, 0, 1);
   endtask

   task automatic t_atomic();
      drive(1, 3'd3, 32'h3000, 0, 0, 0, 1, 0, 0, 1);
      expect_evt("R3 atomic", 2'd2, 32'h3000, 0, 1);
   endtask

   task automatic t_illegal();
      for (int k = 4; k < 8; k++) begin
         drive(1, 3'(k), 32'h4000, 0, 1, 0, 1, 1, 0, 1);
         check("R4 error", req_error, 1);
         check("R4 ready", req_ready, 1);
         check("R4 no event", evt_valid, 0);
      end
   endtask

   task automatic t_wrong_cache();
      drive(1, 3'd0, 32'h5000, 1, 1, 0, 0, 1, 0, 1);
      expect_evt("R5 load in icache", 2'd3, 32'h5000, 1, 0);
      drive(1, 3'd0, 32'h5000, 0, 1, 0, 0, 1, 0, 1);
      expect_evt("R5 then own load", 2'd0, 32'h5000, 0, 1);
      drive(1, 3'd1, 32'h5100, 0, 1, 0, 1, 1, 0, 1);
      expect_evt("R5 ifetch in dcache", 2'd3, 32'h5100, 0, 0);
   endtask

   task automatic t_free_way();
      drive(1, 3'd2, 32'h6000, 0, 0, 32'h1, 0, 1, 32'h2, 1);
      expect_evt("R6 store fill", 2'd2, 32'h6000, 0, 1);
      drive(1, 3'd1, 32'h6100, 0, 1, 32'h1, 0, 0, 32'h2, 1);
      expect_evt("R6 ifetch fill", 2'd1, 32'h6100, 1, 1);
   endtask

   task automatic t_full_set();
      drive(1, 3'd0, 32'h7000, 0, 1, 32'hA1A1, 0, 0, 32'hD7D7, 1);
      expect_evt("R7 data victim", 2'd3, 32'hD7D7, 0, 0);
      drive(1, 3'd1, 32'h7100, 0, 0, 32'hA1A1, 0, 1, 32'hD7D7, 1);
      expect_evt("R7 instr victim", 2'd3, 32'hA1A1, 1, 0);
   endtask

   task automatic t_priority();
      drive(1, 3'd0, 32'h8000, 1, 0, 32'hA1A1, 0, 0, 32'hD7D7, 1);
      expect_evt("R9 wrong cache before victim", 2'd3, 32'h8000, 1, 0);
   endtask

   task automatic t_backpressure();
      drive(1, 3'd0, 32'h9000, 0, 0, 0, 1, 0, 0, 0);
      check("R8 valid while stalled", evt_valid, 1);
      check("R8 held", req_ready, 0);
      drive(1, 3'd0, 32'h9000, 0, 0, 0, 1, 0, 0, 1);
      check("R8 popped", req_ready, 1);
      drive(1, 3'd0, 32'h9100, 0, 1, 0, 0, 0, 32'h55, 1);
      check("R8 replace not popped", req_ready, 0);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R10 reset valid", evt_valid, 0);
      check("R10 reset ready", req_ready, 0);
      rst_n = 1'b1;
      t_idle();
      t_ifetch_hit();
      t_load_hit();
      t_atomic();
      t_illegal();
      t_wrong_cache();
      t_free_way();
      t_full_set();
      t_priority();
      t_backpressure();
      drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 1);
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule